// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a memory-mapped watchdog. A slow-clock enable, synchronous to the bus clock, passes through a fixed prescaler. Each prescaler wrap is one tick, and each tick moves a down-counter. When the counter runs out, the block raises an error flag. It can also raise a sticky reset request, aimed either at the whole system or only at the processor. Software keeps the counter alive by writing a restart command. That command takes effect only when it carries the right key, and only while the counter has dropped into the restart window.

The configuration word can be written once after reset. Later writes to it are ignored, so a runaway program cannot loosen the watchdog. The same word can disable the counter outright or freeze it while an external debug request is high. The status word reports the two sticky error causes and the live counter value, and reading it clears the causes.

Top module: `wdog_win`

## Requirements
- R1: After reset, the mode word (address 1) reads reload = all ones in bits [11:0], delta = all ones in bits [23:12], reset-enable bit 24 = 1, and bits 25 (processor-only), 26 (debug-halt) and 27 (disable) = 0. The counter starts at all ones.
- R2: While running, one tick occurs every PRESC_DIV asserted cycles of slow_en_i, and each tick lowers the counter by one.
- R3: With a reload value N, underflow occurs on the (N+1)-th tick after a load, and the counter then reloads to N.
- R4: Only the first write to the mode word after reset takes effect. That write also loads the counter and clears the prescaler. Later mode writes change nothing.
- R5: A write to address 0 restarts the counter only when bits [31:24] equal 0xA5 and bit 0 is 1. Any other control write has no effect.
- R6: With the disable bit set, the counter holds its value, no reset request is raised, and restarts are ignored.
- R7: Underflow sets the status bit 0 flag. When reset-enable is set, it also raises a request: cpu_rst_req_o if the processor-only bit is set, otherwise sys_rst_req_o. At most one request is ever high, and it stays high until rst_ni.
- R8: With debug-halt set, the counter and prescaler hold while dbg_req_i is high.
- R9: A keyed restart while the counter is above delta is rejected. The counter is not reloaded, status bit 1 is set, and a request is raised if reset-enable is set. When delta is all ones, every keyed restart is accepted.
- R10: A read of address 2 returns the underflow flag in bit 0, the rejection flag in bit 1 and the counter in bits [27:16], and clears both flags. A flag set in the same cycle wins. err_o is the OR of the two flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_en_i | input | 1 | One-cycle enable per slow-clock period |
| dbg_req_i | input | 1 | Debug request; halts counting when enabled |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 control, 1 mode, 2 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| sys_rst_req_o | output | 1 | Sticky system reset request |
| cpu_rst_req_o | output | 1 | Sticky processor-only reset request |
| err_o | output | 1 | OR of the sticky status flags |

## Verification
The bench keeps the 12-bit counter width but sets PRESC_DIV to 4. At that setting a full reload-to-underflow period, the restart window being reached from above, and the underflow after a debug halt all fit within a few hundred cycles. The width stays at 12 so that the all-ones delta, which opens the window completely, and the all-ones reset value are exercised exactly as built. The slow enable runs either every cycle or every third cycle, so the prescaler is checked under gapped input as well.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned BUS_W        = 32;
  localparam int unsigned OPT_W        = 4;
  localparam int unsigned KEY_W        = 8;
  localparam int unsigned STAT_CNT_LSB = 16;

  typedef enum logic [1:0] {
    WD_CTRL = 2'd0,
    WD_MODE = 2'd1,
    WD_STAT = 2'd2
  } wd_addr_e;

  // bit 0 of the packed struct is rst_en
  typedef struct packed {
    logic dis;
    logic dbg_halt;
    logic cpu_only;
    logic rst_en;
  } wd_opt_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic slow_en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic          wrap;

  assign wrap   = (pre_q == LAST);
  assign tick_o = run_i && slow_en_i && wrap && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (clr_i)              pre_q <= '0;
    else if (run_i && slow_en_i) pre_q <= wrap ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             unf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign unf_o = tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned     CNT_W = 12,
  parameter logic [KEY_W-1:0] KEY  = 8'hA5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [1:0]       addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             unf_evt_i,
  input  logic             win_evt_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] delta_o,
  output wd_opt_t          opt_o,
  output logic             locked_o,
  output logic             mode_load_o,
  output logic             restart_o,
  output logic             unf_flag_o,
  output logic             win_flag_o
);
  localparam int unsigned DLT_LSB = CNT_W;
  localparam int unsigned OPT_LSB = 2 * CNT_W;
  localparam int unsigned KEY_LSB = BUS_W - KEY_W;

  logic [CNT_W-1:0] reload_q, delta_q;
  wd_opt_t          opt_q;
  logic             locked_q, unf_q, win_q, stat_rd;

  assign mode_load_o = wr_en_i && (addr_i == WD_MODE) && !locked_q;
  assign restart_o   = wr_en_i && (addr_i == WD_CTRL) &&
                       (wdata_i[KEY_LSB +: KEY_W] == KEY) && wdata_i[0];
  assign stat_rd     = rd_en_i && (addr_i == WD_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '1;
      delta_q  <= '1;
      opt_q    <= '{dis: 1'b0, dbg_halt: 1'b0, cpu_only: 1'b0, rst_en: 1'b1};
      locked_q <= 1'b0;
    end else if (mode_load_o) begin
      reload_q <= wdata_i[0 +: CNT_W];
      delta_q  <= wdata_i[DLT_LSB +: CNT_W];
      opt_q    <= wd_opt_t'(wdata_i[OPT_LSB +: OPT_W]);
      locked_q <= 1'b1;
    end
  end

  // set beats read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unf_q <= 1'b0;
      win_q <= 1'b0;
    end else begin
      unf_q <= unf_evt_i || (unf_q && !stat_rd);
      win_q <= win_evt_i || (win_q && !stat_rd);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (wd_addr_e'(addr_i))
      WD_MODE: begin
        rdata_o[0 +: CNT_W]       = reload_q;
        rdata_o[DLT_LSB +: CNT_W] = delta_q;
        rdata_o[OPT_LSB +: OPT_W] = opt_q;
      end
      WD_STAT: begin
        rdata_o[STAT_CNT_LSB +: CNT_W] = cnt_i;
        rdata_o[1]                     = win_q;
        rdata_o[0]                     = unf_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign reload_o   = reload_q;
  assign delta_o    = delta_q;
  assign opt_o      = opt_q;
  assign locked_o   = locked_q;
  assign unf_flag_o = unf_q;
  assign win_flag_o = win_q;
endmodule

// File: rtl/wdog_win.sv
module wdog_win
  import wdog_pkg::*;
#(
  parameter int unsigned      CNT_W     = 12,
  parameter int unsigned      PRESC_DIV = 128,
  parameter logic [KEY_W-1:0] KEY       = 8'hA5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        slow_en_i,
  input  logic        dbg_req_i,
  input  logic        wr_en_i,
  input  logic        rd_en_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        sys_rst_req_o,
  output logic        cpu_rst_req_o,
  output logic        err_o
);
  logic [CNT_W-1:0] cnt_q, reload, delta, load_val;
  wd_opt_t          opt;
  logic locked, mode_load, restart, hit, accept, reject;
  logic run, tick, unf, raise, load;
  logic unf_flag, win_flag, sys_q, cpu_q;

  assign run      = !opt.dis && !(opt.dbg_halt && dbg_req_i);
  assign hit      = restart && !opt.dis;
  assign accept   = hit && (cnt_q <= delta);
  assign reject   = hit && !accept;
  assign load     = mode_load || accept;
  assign load_val = mode_load ? wdata_i[CNT_W-1:0] : reload;
  assign raise    = opt.rst_en && (unf || reject);

  wdog_regs #(.CNT_W(CNT_W), .KEY(KEY)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .cnt_i(cnt_q), .unf_evt_i(unf), .win_evt_i(reject),
    .rdata_o, .reload_o(reload), .delta_o(delta), .opt_o(opt),
    .locked_o(locked), .mode_load_o(mode_load), .restart_o(restart),
    .unf_flag_o(unf_flag), .win_flag_o(win_flag)
  );

  wdog_prescaler #(.DIV(PRESC_DIV)) u_pre (
    .clk_i, .rst_ni, .run_i(run), .slow_en_i, .clr_i(load), .tick_o(tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .tick_i(tick),
    .reload_i(reload), .cnt_o(cnt_q), .unf_o(unf)
  );

  // first request wins and holds until rst_ni
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_q <= 1'b0;
      cpu_q <= 1'b0;
    end else if (raise && !sys_q && !cpu_q) begin
      if (opt.cpu_only) cpu_q <= 1'b1;
      else              sys_q <= 1'b1;
    end
  end

  assign sys_rst_req_o = sys_q;
  assign cpu_rst_req_o = cpu_q;
  assign err_o         = unf_flag || win_flag;
endmodule

// File: rtl/wdog_win_chk.sv
module wdog_win_chk
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dbg_req_i,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] delta,
  input wd_opt_t          opt,
  input logic             locked,
  input logic             accept,
  input logic             reject,
  input logic             sys_o,
  input logic             cpu_o,
  input logic             err_o
);
  a_r4_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(reload) && $stable(delta) && $stable(opt));

  a_r6_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked && opt.dis |=> $stable(cnt) && !$rose(sys_o) && !$rose(cpu_o));

  a_r8_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked && opt.dbg_halt && dbg_req_i && !accept |=> $stable(cnt));

  a_r9_reject_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> err_o);

  a_r7_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sys_o && cpu_o));

  a_r7_req_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_o || cpu_o) |=> $stable({sys_o, cpu_o}));

  a_r2_tick_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= reload);
endmodule

bind wdog_win wdog_win_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .dbg_req_i(dbg_req_i), .tick(tick),
  .cnt(cnt_q), .reload(reload), .delta(delta), .opt(opt), .locked(locked),
  .accept(accept), .reject(reject), .sys_o(sys_rst_req_o),
  .cpu_o(cpu_rst_req_o), .err_o(err_o)
);

// File: tb/tb_wdog_win.sv
`timescale 1ns/1ps
module tb_wdog_win;
  localparam int DIV = 4;
  localparam int CW  = 12;
  localparam int FULL = (1 << CW) - 1;

  logic clk = 0, rst_ni = 0, slow_en = 0, dbg_req = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic sys_o, cpu_o, err_o;

  int checks = 0, errors = 0, cyc = 0;
  bit sparse = 0, done = 0;

  // reference model state
  int m_pre, m_cnt, m_reload, m_delta;
  bit m_rst_en, m_cpu, m_halt, m_dis, m_locked, m_unf, m_win, m_sreq, m_creq;

  always #2.5 clk = ~clk;

  wdog_win #(.CNT_W(CW), .PRESC_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .slow_en_i(slow_en), .dbg_req_i(dbg_req),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sys_rst_req_o(sys_o), .cpu_rst_req_o(cpu_o), .err_o(err_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_mode(int rl, int dl, bit rst_en, bit cpu, bit halt, bit dis);
    return {4'b0, dis, halt, cpu, rst_en, dl[11:0], rl[11:0]};
  endfunction

  function automatic logic [31:0] m_rdata(logic [1:0] a);
    logic [31:0] r = '0;
    if (a == 2'd1) r = {4'b0, m_dis, m_halt, m_cpu, m_rst_en, m_delta[11:0], m_reload[11:0]};
    else if (a == 2'd2) begin r[27:16] = m_cnt[11:0]; r[1] = m_win; r[0] = m_unf; end
    return r;
  endfunction

  task automatic m_raise();
    if (m_rst_en && !m_sreq && !m_creq) begin
      if (m_cpu) m_creq = 1; else m_sreq = 1;
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_cnt = FULL; m_reload = FULL; m_delta = FULL;
      m_rst_en = 1; m_cpu = 0; m_halt = 0; m_dis = 0; m_locked = 0;
      m_unf = 0; m_win = 0; m_sreq = 0; m_creq = 0;
    end else begin
      bit run, tck, hit;
      run = !m_dis && !(m_halt && dbg_req);
      tck = 0;
      if (run && slow_en) begin
        if (m_pre == DIV - 1) begin m_pre = 0; tck = 1; end
        else m_pre++;
      end
      hit = wr_en && addr == 2'd0 && wdata[31:24] == 8'hA5 && wdata[0] && !m_dis;
      if (rd_en && addr == 2'd2) begin m_unf = 0; m_win = 0; end
      if (wr_en && addr == 2'd1 && !m_locked) begin
        m_reload = wdata[11:0]; m_delta = wdata[23:12];
        m_rst_en = wdata[24]; m_cpu = wdata[25]; m_halt = wdata[26]; m_dis = wdata[27];
        m_locked = 1; m_cnt = m_reload; m_pre = 0;
      end else if (hit && m_cnt <= m_delta) begin
        m_cnt = m_reload; m_pre = 0;
      end else begin
        if (hit) begin m_win = 1; m_raise(); end
        if (tck) begin
          if (m_cnt == 0) begin m_cnt = m_reload; m_unf = 1; m_raise(); end
          else m_cnt--;
        end
      end
    end
  end

  // per-clock comparison of the registered outputs
  always @(negedge clk) begin
    cyc++;
    slow_en = sparse ? (cyc % 3 == 0) : 1'b1;
    if (rst_ni && !done) begin
      chk("R7 sys request", sys_o, m_sreq);
      chk("R7 cpu request", cpu_o, m_creq);
      chk("R10 err_o", err_o, m_unf | m_win);
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; dbg_req = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic bus_wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bus_rd(logic [1:0] a, string req, output logic [31:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    #1; v = rdata;
    chk(req, v, m_rdata(a));
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    do_reset();

    // R1 reset values
    bus_rd(2'd1, "R1 mode after reset", v);
    chk("R1 mode literal", v, 32'h01FF_FFFF);
    bus_rd(2'd2, "R1 status after reset", v);
    chk("R1 counter full", {20'b0, v[27:16]}, FULL);

    // R3 period and R4 write-once
    bus_wr(2'd1, mk_mode(10, FULL, 1, 0, 0, 0));
    n = 0;
    while (!err_o && n < 1000) begin @(negedge clk); n++; end
    chk("R3 underflow after N+1 ticks", n, 11 * DIV);
    chk("R7 system request", sys_o, 1);
    bus_wr(2'd1, mk_mode(77, 5, 0, 1, 1, 1));
    bus_rd(2'd1, "R4 second mode write ignored", v);
    chk("R4 mode literal", v, mk_mode(10, FULL, 1, 0, 0, 0));
    bus_rd(2'd2, "R10 status with underflow", v);
    chk("R10 underflow bit", v[0], 1);
    bus_rd(2'd2, "R10 status cleared", v);
    chk("R10 flags cleared", v[1:0], 0);
    chk("R7 request stays", sys_o, 1);

    // R5 key handling, R9 full-scale window
    do_reset();
    bus_wr(2'd1, mk_mode(200, FULL, 1, 0, 0, 0));
    wait_cyc(100);
    bus_wr(2'd0, 32'h5A00_0001);
    bus_rd(2'd2, "R5 wrong key", v);
    chk("R5 wrong key no reload", v[27:16] < 200, 1);
    bus_wr(2'd0, 32'hA500_0000);
    bus_rd(2'd2, "R5 missing restart bit", v);
    chk("R5 no restart bit no reload", v[27:16] < 200, 1);
    bus_wr(2'd0, 32'hA500_0001);
    bus_rd(2'd2, "R9 full window accept", v);
    chk("R5 keyed restart reloads", v[27:16], 200);

    // R9 rejection without reset enable, then acceptance in window
    do_reset();
    bus_wr(2'd1, mk_mode(100, 20, 0, 0, 0, 0));
    bus_wr(2'd0, 32'hA500_0001);
    chk("R9 reject no request", sys_o | cpu_o, 0);
    bus_rd(2'd2, "R9 reject flag", v);
    chk("R9 window flag", v[1], 1);
    bus_rd(2'd2, "R10 flag cleared", v);
    chk("R10 window flag cleared", v[1], 0);
    while (m_cnt > 15) @(negedge clk);
    bus_wr(2'd0, 32'hA500_0001);
    bus_rd(2'd2, "R9 accept in window", v);
    chk("R9 in-window reload", v[27:16], 100);
    chk("R9 in-window no flag", v[1], 0);

    // R9 rejection with reset enable
    do_reset();
    bus_wr(2'd1, mk_mode(100, 20, 1, 0, 0, 0));
    bus_wr(2'd0, 32'hA500_0001);
    chk("R9 reject raises request", sys_o, 1);

    // R6 disable
    do_reset();
    bus_wr(2'd1, mk_mode(5, FULL, 1, 0, 0, 1));
    wait_cyc(200);
    bus_wr(2'd0, 32'hA500_0001);
    chk("R6 no request", sys_o | cpu_o | err_o, 0);
    bus_rd(2'd2, "R6 counter frozen", v);
    chk("R6 counter value", v[27:16], 5);

    // R8 debug halt
    do_reset();
    bus_wr(2'd1, mk_mode(50, FULL, 1, 0, 1, 0));
    dbg_req = 1;
    wait_cyc(100);
    bus_rd(2'd2, "R8 halted", v);
    chk("R8 counter held", v[27:16], 50);
    dbg_req = 0;
    wait_cyc(40);
    bus_rd(2'd2, "R8 resumed", v);
    chk("R8 counting resumed", v[27:16] < 50, 1);

    // R7 processor-only request
    do_reset();
    bus_wr(2'd1, mk_mode(3, FULL, 1, 1, 0, 0));
    wait_cyc(30);
    chk("R7 cpu request", cpu_o, 1);
    chk("R7 no system request", sys_o, 0);

    // R7 reset disabled: flag only
    do_reset();
    bus_wr(2'd1, mk_mode(3, FULL, 0, 0, 0, 0));
    wait_cyc(30);
    chk("R7 flag without request", {err_o, sys_o, cpu_o}, 3'b100);

    // R2 gapped slow enable
    do_reset();
    sparse = 1;
    bus_wr(2'd1, mk_mode(5, FULL, 1, 0, 0, 0));
    n = 0;
    while (!err_o && n < 1000) begin @(negedge clk); n++; end
    chk("R2 gapped enable slows ticks", n > 6 * DIV, 1);
    sparse = 0;

    wait_cyc(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule